// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state of every line of one private write-back, write-allocate cache that shares a snooping bus with other caches. Each line is Invalid, Shared, Exclusive or Modified. The state array is direct-mapped and holds one tag and one state per line. The low `IDX_W` bits of a line address select the entry. The remaining bits form the tag.

The processor side presents one read or write request and holds it until `cpuDone`. A hit that needs no bus traffic completes at once. A miss, or a write to a Shared line, raises `busReq` with a command and waits for `busGnt`. Only after the grant does the line reach its final state. On the snoop side, the block compares the address of each transaction from another cache against the array. In the next cycle it reports whether it holds the line, whether it drives the data, and whether memory must take a copy. It also updates the line state.

After a read miss, the line becomes Exclusive when no other cache reports the line. It becomes Shared when some cache does. A snooped transaction always takes effect before processor work that falls in the same cycle.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so a snoop to any address gives `snpHit`=0. `busReq`, `busCmd`, `cpuDone`, `snpHit`, `snpSupply` and `snpFlush` are all 0.
- R2: A processor read that misses raises `busReq` with `busCmd`=1 (bus read) and `busAddr` equal to the request address. A tag mismatch at a valid index also counts as a miss. `busShared` is sampled in the cycle after the one with `busGnt` high. The line ends Exclusive if `busShared` was 0 and Shared if it was 1.
- R3: A processor read to a valid line completes with `cpuDone` in the next cycle and `cpuHit`=1. It raises no bus request.
- R4: A processor write to an Exclusive or Modified line makes it Modified without any bus request, and completes with `cpuHit`=1.
- R5: A processor write to a Shared line raises `busReq` with `busCmd`=3 (invalidate). The line becomes Modified once granted. The write completes with `cpuHit`=0.
- R6: A processor write that misses raises `busReq` with `busCmd`=2 (bus write miss). The line ends Modified after the grant.
- R7: A snooped bus read (`snpCmd`=1) to a valid line gives `snpHit`=1 one cycle later and turns Exclusive or Modified into Shared. A Modified line also raises `snpFlush` for that cycle.
- R8: A snooped bus write miss (`snpCmd`=2) or invalidate (`snpCmd`=3) to a valid line gives `snpHit`=1 one cycle later and makes the line Invalid.
- R9: `snpSupply` rises one cycle after a snooped bus read or bus write miss that hits a valid line, but only when `snpSupplyBusy` was 0 in the snoop cycle. An invalidate never supplies data.
- R10: In a cycle with `snpValid` high, no processor lookup takes place. A snoop that invalidates the requested line therefore turns the processor's next lookup into a miss.
- R11: A pending invalidate whose line is invalidated by a snoop before the grant changes `busCmd` from 3 to 2. The line still ends Modified.
- R12: A snoop that lands in the cycle after a read-miss grant acts on the newly filled line, and its effect takes priority over the Exclusive/Shared choice. A snooped write miss leaves the line Invalid.
- R13: While waiting for the grant, `busReq`, `busCmd` and `busAddr` stay steady.
- R14: `cpuDone` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor request, held until `cpuDone` |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Processor line address |
| cpuDone | output | 1 | Request complete (one-cycle pulse) |
| cpuHit | output | 1 | With `cpuDone`: completed without bus traffic |
| busReq | output | 1 | Bus arbitration request |
| busCmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 invalidate |
| busAddr | output | ADDR_W | Line address of the requested transaction |
| busGnt | input | 1 | Bus granted; the transaction goes out this cycle |
| busShared | input | 1 | Wired-OR line-present response, the cycle after the grant |
| snpValid | input | 1 | Transaction from another cache on the bus |
| snpCmd | input | 2 | Snooped command, same encoding as `busCmd` |
| snpAddr | input | ADDR_W | Snooped line address |
| snpSupplyBusy | input | 1 | Another cache has already claimed the data slot |
| snpHit | output | 1 | This cache holds the snooped line (registered) |
| snpSupply | output | 1 | This cache drives the data (registered) |
| snpFlush | output | 1 | Memory must take this cache's dirty copy (registered) |

## Verification
The processor side and the snoop side can both reach the state array in the same cycle. The bench provokes this three ways. It drives a processor read and a snooped write miss to the same line in one cycle. It sends a snooped invalidate while an upgrade is waiting for its grant. It sends a snooped write miss in the cycle where a read fill picks Exclusive or Shared. The outcome is judged from the ports alone: whether the later lookup misses, which command the bus request carries, and whether a later snoop still finds the line.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  // Line states; the encoding is internal to the block.
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } lineState_t;

  // Bus command codes, shared by own requests and snooped traffic.
  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_WR   = 2'd2,
    BC_INV  = 2'd3
  } busCmd_t;

  // Strobes from the control to the state array.
  typedef struct packed {
    logic       wrEn;     // write the state of the target entry
    logic       wrTag;    // also load the target tag (line fill)
    lineState_t wrState;  // state to write
  } arrStrobe_t;

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] tgtAddr,
  input  arrStrobe_t        strb,
  output logic              tgtHit,
  output lineState_t        tgtState,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              snpSupplyBusy,
  output logic              snpHit,
  output logic              snpSupply,
  output logic              snpFlush
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0] tagMem [LINES];
  lineState_t       stMem  [LINES];

  logic [IDX_W-1:0] tIdx, sIdx;
  logic [TAG_W-1:0] tTag, sTag;
  lineState_t       sState, sNext;
  logic             sHit, sApply;
  logic             supplyCmd;

  assign tIdx = tgtAddr[IDX_W-1:0];
  assign tTag = tgtAddr[ADDR_W-1:IDX_W];
  assign sIdx = snpAddr[IDX_W-1:0];
  assign sTag = snpAddr[ADDR_W-1:IDX_W];

  // Processor-side lookup on the target address.
  assign tgtState = stMem[tIdx];
  assign tgtHit   = (stMem[tIdx] != LS_I) && (tagMem[tIdx] == tTag);

  // Snoop-side lookup.
  assign sState = stMem[sIdx];
  assign sHit   = (sState != LS_I) && (tagMem[sIdx] == sTag);
  assign sApply = snpValid && sHit;

  always_comb begin
    sNext = sState;
    unique case (busCmd_t'(snpCmd))
      BC_RD:         sNext = LS_S;
      BC_WR, BC_INV: sNext = LS_I;
      default:       sNext = sState;
    endcase
  end

  assign supplyCmd = (busCmd_t'(snpCmd) == BC_RD) || (busCmd_t'(snpCmd) == BC_WR);

  // One writer per entry; a snoop hit wins over a control strobe.
  for (genvar g = 0; g < LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stMem[g]  <= LS_I;
        tagMem[g] <= '0;
      end else if (sApply && (sIdx == IDX_W'(g))) begin
        stMem[g] <= sNext;
      end else if (strb.wrEn && (tIdx == IDX_W'(g))) begin
        stMem[g] <= strb.wrState;
        if (strb.wrTag) tagMem[g] <= tTag;
      end
    end
  end

  // Registered snoop responses, valid the cycle after the snoop.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snpHit    <= 1'b0;
      snpSupply <= 1'b0;
      snpFlush  <= 1'b0;
    end else begin
      snpHit    <= sApply;
      snpSupply <= sApply && supplyCmd && !snpSupplyBusy;
      snpFlush  <= sApply && (busCmd_t'(snpCmd) == BC_RD) && (sState == LS_M);
    end
  end

endmodule

// File: rtl/mesi_req_ctrl.sv
module mesi_req_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuDone,
  output logic              cpuHit,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busGnt,
  input  logic              busShared,
  input  logic              snpValid,
  input  logic              tgtHit,
  input  lineState_t        tgtState,
  output logic [ADDR_W-1:0] tgtAddr,
  output arrStrobe_t        strb
);

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_WAIT = 2'd1,
    C_FILL = 2'd2,
    C_DONE = 2'd3
  } ctrlState_t;

  ctrlState_t        cs, nextCs;
  logic [ADDR_W-1:0] pendAddr, nextAddr;
  busCmd_t           pendCmd, nextCmd, effCmd;
  logic              hitFlag, nextHit;

  // An upgrade that lost its copy while waiting becomes a write miss.
  assign effCmd = ((pendCmd == BC_INV) && !tgtHit) ? BC_WR : pendCmd;

  assign tgtAddr = (cs == C_IDLE) ? cpuAddr : pendAddr;
  assign cpuDone = (cs == C_DONE);
  assign cpuHit  = hitFlag;
  assign busReq  = (cs == C_WAIT);
  assign busCmd  = (cs == C_WAIT) ? effCmd : BC_NONE;
  assign busAddr = (cs == C_WAIT) ? pendAddr : '0;

  always_comb begin
    nextCs   = cs;
    nextAddr = pendAddr;
    nextCmd  = pendCmd;
    nextHit  = hitFlag;
    strb     = '0;
    unique case (cs)
      C_IDLE: begin
        // A snooped transaction in this cycle goes first.
        if (cpuReq && !snpValid) begin
          nextAddr = cpuAddr;
          if (tgtHit && !cpuWrite) begin
            nextHit = 1'b1;
            nextCs  = C_DONE;
          end else if (tgtHit && (tgtState != LS_S)) begin
            strb.wrEn    = 1'b1;
            strb.wrState = LS_M;
            nextHit      = 1'b1;
            nextCs       = C_DONE;
          end else begin
            nextHit = 1'b0;
            nextCmd = tgtHit ? BC_INV : (cpuWrite ? BC_WR : BC_RD);
            nextCs  = C_WAIT;
          end
        end
      end
      C_WAIT: begin
        if (busGnt) begin
          strb.wrEn    = 1'b1;
          strb.wrTag   = 1'b1;
          strb.wrState = (effCmd == BC_RD) ? LS_E : LS_M;
          nextCs       = (effCmd == BC_RD) ? C_FILL : C_DONE;
        end
      end
      C_FILL: begin
        if (busShared) begin
          strb.wrEn    = 1'b1;
          strb.wrState = LS_S;
        end
        nextCs = C_DONE;
      end
      default: nextCs = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cs       <= C_IDLE;
      pendAddr <= '0;
      pendCmd  <= BC_NONE;
      hitFlag  <= 1'b0;
    end else begin
      cs       <= nextCs;
      pendAddr <= nextAddr;
      pendCmd  <= nextCmd;
      hitFlag  <= nextHit;
    end
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuDone,
  output logic              cpuHit,
  output logic              busReq,
  output logic [1:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busGnt,
  input  logic              busShared,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              snpSupplyBusy,
  output logic              snpHit,
  output logic              snpSupply,
  output logic              snpFlush
);

  logic [ADDR_W-1:0] tgtAddr;
  logic              tgtHit;
  lineState_t        tgtState;
  arrStrobe_t        strb;

  mesi_req_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuDone(cpuDone), .cpuHit(cpuHit),
    .busReq(busReq), .busCmd(busCmd), .busAddr(busAddr),
    .busGnt(busGnt), .busShared(busShared), .snpValid(snpValid),
    .tgtHit(tgtHit), .tgtState(tgtState), .tgtAddr(tgtAddr), .strb(strb)
  );

  mesi_state_array #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uArr (
    .clk(clk), .rstN(rstN),
    .tgtAddr(tgtAddr), .strb(strb), .tgtHit(tgtHit), .tgtState(tgtState),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpSupplyBusy(snpSupplyBusy),
    .snpHit(snpHit), .snpSupply(snpSupply), .snpFlush(snpFlush)
  );

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuDone,
  input logic              cpuHit,
  input logic              busReq,
  input logic [1:0]        busCmd,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busGnt,
  input logic              snpValid,
  input logic [1:0]        snpCmd,
  input logic              snpSupplyBusy,
  input logic              snpHit,
  input logic              snpSupply,
  input logic              snpFlush
);

  a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

  a_r13_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt) |=> (busReq && $stable(busAddr)));

  a_r9_busy_blocks_supply: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpSupplyBusy) |=> !snpSupply);

  a_r9_supply_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    snpSupply |-> snpHit);

  a_r7_flush_on_read: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> ($past(snpValid) && ($past(snpCmd) == 2'd1)));

  a_r4_hit_without_bus: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && cpuHit) |-> !$past(busReq));

  a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |-> (busCmd == 2'd0));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;

  localparam int AW = 12;
  localparam logic [1:0] RD = 2'd1, WR = 2'd2, INV = 2'd3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic          cpuDone, cpuHit, busReq;
  logic [1:0]    busCmd;
  logic [AW-1:0] busAddr;
  logic          busGnt = 1'b0, busShared = 1'b0;
  logic          snpValid = 1'b0, snpSupplyBusy = 1'b0;
  logic [1:0]    snpCmd = 2'd0;
  logic [AW-1:0] snpAddr = '0;
  logic          snpHit, snpSupply, snpFlush;

  mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(3)) u0 (.*);

  int  checks = 0, failures = 0;
  bit  finished = 0;
  bit    expHitQ[$];
  string expTagQ[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected completion per cpuDone pulse.
  always @(negedge clk) begin
    if (rstN && cpuDone) begin
      if (expHitQ.size() == 0) chk(1'b0, "R14", "unexpected done", 1, 0);
      else begin
        automatic bit    e = expHitQ.pop_front();
        automatic string t = expTagQ.pop_front();
        chk(cpuHit == e, t, "cpuHit", cpuHit, e);
      end
    end
  end

  task automatic waitDone();
    while (!cpuDone) @(negedge clk);
    cpuReq = 1'b0;
    @(negedge clk);
    chk(cpuDone == 1'b0, "R14", "done width", cpuDone, 0);
  endtask

  task automatic grantOnce(input logic [1:0] cmd, input bit shr);
    busGnt = 1'b1;
    @(negedge clk);
    busGnt = 1'b0;
    if (cmd == RD) begin
      busShared = shr;
      @(negedge clk);
      busShared = 1'b0;
    end
  endtask

  // Driver: one processor request; pushes the expected completion.
  task automatic cpuOp(input bit wr, input logic [AW-1:0] a, input bit shr,
                       input bit expHit, input logic [1:0] expCmd,
                       input int gntDelay, input string tag);
    expHitQ.push_back(expHit);
    expTagQ.push_back(tag);
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = a;
    @(negedge clk);
    if (expHit) begin
      chk(busReq == 1'b0, tag, "busReq on hit", busReq, 0);
    end else begin
      chk(busReq == 1'b1, tag, "busReq", busReq, 1);
      chk(busCmd == expCmd, tag, "busCmd", busCmd, expCmd);
      chk(busAddr == a, tag, "busAddr", busAddr, a);
      for (int i = 0; i < gntDelay; i++) begin
        @(negedge clk);
        chk(busReq && (busCmd == expCmd) && (busAddr == a), "R13",
            "request held", busCmd, expCmd);
      end
      grantOnce(expCmd, shr);
    end
    waitDone();
  endtask

  task automatic snoopOp(input logic [1:0] cmd, input logic [AW-1:0] a,
                         input bit busy, input bit eHit, input bit eSup,
                         input bit eFl, input string tag);
    @(negedge clk);
    snpValid = 1'b1; snpCmd = cmd; snpAddr = a; snpSupplyBusy = busy;
    @(negedge clk);
    snpValid = 1'b0; snpSupplyBusy = 1'b0;
    chk(snpHit == eHit, tag, "snpHit", snpHit, eHit);
    chk(snpSupply == eSup, tag, "snpSupply", snpSupply, eSup);
    chk(snpFlush == eFl, tag, "snpFlush", snpFlush, eFl);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busReq && busCmd == 2'd0 && !cpuDone, "R1", "bus/cpu idle", busReq, 0);
    chk(!snpHit && !snpSupply && !snpFlush, "R1", "snoop idle", snpHit, 0);
    rstN = 1'b1;
    snoopOp(RD, 12'h010, 0, 0, 0, 0, "R1");

    // Line 0x011: E, hit, silent upgrade, shared by snoop, upgrade, invalidate
    cpuOp(0, 12'h011, 0, 0, RD, 0, "R2");
    cpuOp(0, 12'h011, 0, 1, RD, 0, "R3");
    cpuOp(1, 12'h011, 0, 1, RD, 0, "R4");
    snoopOp(RD, 12'h011, 0, 1, 1, 1, "R7");
    cpuOp(1, 12'h011, 0, 0, INV, 2, "R5");
    snoopOp(WR, 12'h011, 0, 1, 1, 0, "R8");
    snoopOp(RD, 12'h011, 0, 0, 0, 0, "R8");

    // Line 0x022: shared fill, busy supply slot, upgrade, then dirty
    cpuOp(0, 12'h022, 1, 0, RD, 0, "R2");
    snoopOp(RD, 12'h022, 1, 1, 0, 0, "R9");
    cpuOp(1, 12'h022, 0, 0, INV, 0, "R5");
    snoopOp(RD, 12'h022, 1, 1, 0, 1, "R7");
    // Same index, other tag: miss and replace
    cpuOp(0, 12'h0A2, 0, 0, RD, 1, "R2");
    cpuOp(0, 12'h0A2, 0, 1, RD, 0, "R3");

    // Line 0x033: write miss ends Modified
    cpuOp(1, 12'h033, 0, 0, WR, 0, "R6");
    snoopOp(RD, 12'h033, 0, 1, 1, 1, "R6");

    // R11: upgrade loses its copy while waiting
    cpuOp(0, 12'h044, 1, 0, RD, 0, "R2");
    expHitQ.push_back(1'b0); expTagQ.push_back("R11");
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = 1'b1; cpuAddr = 12'h044;
    @(negedge clk);
    chk(busReq && busCmd == INV, "R5", "upgrade cmd", busCmd, INV);
    snpValid = 1'b1; snpCmd = INV; snpAddr = 12'h044;
    @(negedge clk);
    snpValid = 1'b0;
    chk(snpSupply == 1'b0, "R9", "no supply on invalidate", snpSupply, 0);
    chk(busReq && busCmd == WR, "R11", "converted cmd", busCmd, WR);
    grantOnce(WR, 0);
    waitDone();
    snoopOp(RD, 12'h044, 0, 1, 1, 1, "R11");

    // R10: same-cycle processor read and snooped write miss
    cpuOp(0, 12'h055, 0, 0, RD, 0, "R2");
    expHitQ.push_back(1'b0); expTagQ.push_back("R10");
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = 1'b0; cpuAddr = 12'h055;
    snpValid = 1'b1; snpCmd = WR; snpAddr = 12'h055; snpSupplyBusy = 1'b1;
    @(negedge clk);
    snpValid = 1'b0; snpSupplyBusy = 1'b0;
    chk(snpHit == 1'b1, "R8", "snoop hit on E", snpHit, 1);
    chk(busReq == 1'b0, "R10", "no lookup during snoop", busReq, 0);
    @(negedge clk);
    chk(busReq && busCmd == RD, "R10", "lookup misses after snoop", busCmd, RD);
    grantOnce(RD, 0);
    waitDone();
    // Exclusive line downgraded by snoop read, no flush; write then upgrades
    snoopOp(RD, 12'h055, 0, 1, 1, 0, "R7");
    cpuOp(1, 12'h055, 0, 0, INV, 0, "R7");

    // R12: snoop in the fill cycle wins
    expHitQ.push_back(1'b0); expTagQ.push_back("R12");
    @(negedge clk);
    cpuReq = 1'b1; cpuWrite = 1'b0; cpuAddr = 12'h066;
    @(negedge clk);
    chk(busReq && busCmd == RD, "R12", "fill request", busCmd, RD);
    busGnt = 1'b1;
    @(negedge clk);
    busGnt = 1'b0;
    snpValid = 1'b1; snpCmd = WR; snpAddr = 12'h066; busShared = 1'b1;
    @(negedge clk);
    snpValid = 1'b0; busShared = 1'b0;
    chk(snpHit == 1'b1, "R12", "snoop sees filled line", snpHit, 1);
    waitDone();
    snoopOp(RD, 12'h066, 0, 0, 0, 0, "R12");

    repeat (2) @(negedge clk);
    chk(expHitQ.size() == 0, "R14", "pending completions", expHitQ.size(), 0);
    summary();
  end

endmodule